// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. It drives chip select, serial clock and data-out-to-memory, and samples the memory's data line. A request port takes one command at a time: read, write, erase, enable programming or disable programming. Each request carries an address and, for writes, a data word. The controller builds the serial frame, which is a start bit, a two-bit opcode, the address and, for a write, the data. It shifts the frame out with a serial clock divided from the system clock. For a read it collects the returned word. When the request has finished it pulses `done`.

Programming commands end their frame by dropping chip select with no further rising clock edge. Chip select then stays low for a minimum number of system cycles. After that it is raised again and the memory's data line is polled until it reads high, which means ready. The poll has a cycle limit, and running past it raises an error flag. The memory starts up with programming disabled, and a disable command turns it off again. While programming is off, the controller places an enable frame ahead of any write or erase on its own.

Top module: `mw_eeprom_host`

## Requirements
- R1: While reset is asserted and in the idle state after it, `ee_cs`, `ee_sk`, `done` and `err` are low and `req_ready` is high.
- R2: Command codes are read=0, write=1, erase=2, enable=3, disable=4. A request is accepted when `req_valid` and `req_ready` are both high. For a code from 0 to 4, `req_ready` is low in the cycle after acceptance, and the request produces exactly one single-cycle `done` pulse.
- R3: The first rising `ee_sk` edge with `ee_cs` high carries `ee_di`=1, which is the start bit. Then come two opcode bits: read 10, write 01, erase 11, enable and disable 00. Then come ADDR_W address bits, most significant bit first. Enable puts 11 in the two top address bits and disable puts 00 there. A write adds DATA_W data bits, most significant bit first.
- R4: `ee_sk` is high only while `ee_cs` is high. Each high phase lasts DIV system cycles. `ee_di` does not change while `ee_sk` is high.
- R5: After the address bits of a read, the controller gives DATA_W more clocks. The zero bit that the memory returns with the last address bit is not stored. At `done`, `rdata` holds the word, most significant bit first.
- R6: A write frame ends after its last data bit, and an erase frame ends after its last address bit. In both cases `ee_cs` falls with no extra rising `ee_sk` edge. After the minimum low time, `ee_cs` rises with `ee_sk` low. `ee_do` is then sampled once per divider period. Low means busy; high ends the operation, and `ee_cs` is dropped.
- R7: Each time `ee_cs` falls, it stays low for at least CSL_CYC system cycles before it rises again.
- R8: If `ee_do` has not read high after POLL_MAX polls, `ee_cs` is dropped and `done` comes with `err`=1. `err` returns to 0 when the next request is accepted.
- R9: Programming is off after reset and after a disable frame, and an enable frame turns it on. A write or erase requested while programming is off is sent after an enable frame that the controller adds itself.
- R10: A command code from 5 to 7 gives `done` with `err`=1 one cycle after acceptance, and `ee_cs` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_cmd | input | 3 | Command code |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Idle, able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Word from the last read |
| err | output | 1 | Poll timeout or unknown code, valid at done |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
The bench connects the controller to a behavioural memory that decodes frames, and sends it a fixed sequence of commands. Reads of freshly initialised words, of words just written and of a word just erased show whether the dummy bit is dropped and whether bit order is correct. A write to the top address and a write of an all-zero word mark the edges of the address and data fields. A write issued with programming off, followed by reading the word back, shows whether the automatic enable was sent. The test then makes the memory stay busy forever to reach the timeout. It also resets the controller in the middle of a frame, and checks that a second write after that reset is still preceded by a fresh enable.

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int DIV      = 4,
  parameter int CSL_CYC  = 13,
  parameter int POLL_MAX = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);

  localparam int FW    = 3 + ADDR_W + DATA_W;
  localparam int SHORT = 3 + ADDR_W;
  localparam int CW    = $clog2(FW + 1);
  localparam int DW    = $clog2(DIV + 1);
  localparam int LW    = $clog2(CSL_CYC + 1);
  localparam int PW    = $clog2(POLL_MAX + 1);
  localparam int WW    = (LW > PW) ? LW : PW;

  localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_ER = 3'd2, C_EN = 3'd3, C_DIS = 3'd4;
  localparam logic [1:0] N_DONE = 2'd0, N_FRAME = 2'd1, N_POLL = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL} st_t;
  st_t st;

  logic [FW-1:0]     sh;
  logic [CW-1:0]     bitn, nbits;
  logic [DW-1:0]     divc;
  logic [WW-1:0]     wcnt;
  logic [2:0]        cur, pcmd;
  logic [ADDR_W-1:0] paddr;
  logic [DATA_W-1:0] pdata, rbuf;
  logic              pend, wen;
  logic [1:0]        nx;

  function automatic logic [FW-1:0] frame(input logic [2:0] c, input logic [ADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d);
    case (c)
      C_RD:    return {3'b110, a, {DATA_W{1'b0}}};
      C_WR:    return {3'b101, a, d};
      C_ER:    return {3'b111, a, {DATA_W{1'b0}}};
      C_EN:    return {3'b100, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
      default: return {3'b100, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
    endcase
  endfunction

  function automatic logic [CW-1:0] flen(input logic [2:0] c);
    return (c == C_RD || c == C_WR) ? CW'(FW) : CW'(SHORT);
  endfunction

  wire tick    = divc == DW'(DIV - 1);
  wire prog    = req_cmd == C_WR || req_cmd == C_ER;
  wire need_en = prog && !wen;
  wire [2:0] fcmd = need_en ? C_EN : req_cmd;
  wire cur_prog = cur == C_WR || cur == C_ER;

  assign req_ready = st == S_IDLE;
  assign rdata     = rbuf;
  assign ee_di     = ee_cs & sh[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ee_cs <= 1'b0; ee_sk <= 1'b0; sh <= '0;
      bitn <= '0;    nbits <= '0;   divc <= '0;   wcnt <= '0;
      cur <= C_RD;   pcmd <= C_RD;  paddr <= '0;  pdata <= '0;
      rbuf <= '0;    pend <= 1'b0;  wen <= 1'b0;  nx <= N_DONE;
      done <= 1'b0;  err <= 1'b0;
    end else begin
      done <= 1'b0;
      divc <= tick ? '0 : divc + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          err <= 1'b0;
          if (req_cmd > C_DIS) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            pcmd  <= req_cmd;
            paddr <= req_addr;
            pdata <= req_wdata;
            pend  <= need_en;
            cur   <= fcmd;
            sh    <= frame(fcmd, req_addr, req_wdata);
            nbits <= flen(fcmd);
            bitn  <= '0;
            ee_cs <= 1'b1;
            ee_sk <= 1'b0;
            divc  <= '0;
            st    <= S_SHIFT;
          end
        end
        S_SHIFT: if (tick) begin
          if (!ee_sk) ee_sk <= 1'b1;
          else begin
            ee_sk <= 1'b0;
            if (cur == C_RD && bitn >= CW'(SHORT)) rbuf <= {rbuf[DATA_W-2:0], ee_do};
            sh   <= sh << 1;
            bitn <= bitn + 1'b1;
            if (bitn == nbits - 1'b1) begin
              ee_cs <= 1'b0;
              wcnt  <= '0;
              st    <= S_GAP;
              if (cur == C_EN)  wen <= 1'b1;
              if (cur == C_DIS) wen <= 1'b0;
              nx <= pend ? N_FRAME : (cur_prog ? N_POLL : N_DONE);
            end
          end
        end
        S_GAP: if (wcnt == WW'(CSL_CYC - 1)) begin
          wcnt <= '0;
          divc <= '0;
          case (nx)
            N_FRAME: begin
              pend  <= 1'b0;
              cur   <= pcmd;
              sh    <= frame(pcmd, paddr, pdata);
              nbits <= flen(pcmd);
              bitn  <= '0;
              ee_cs <= 1'b1;
              st    <= S_SHIFT;
            end
            N_POLL: begin
              ee_cs <= 1'b1;
              st    <= S_POLL;
            end
            default: begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          endcase
        end else wcnt <= wcnt + 1'b1;
        S_POLL: if (tick) begin
          if (ee_do || wcnt == WW'(POLL_MAX - 1)) begin
            if (!ee_do) err <= 1'b1;
            ee_cs <= 1'b0;
            wcnt  <= '0;
            nx    <= N_DONE;
            st    <= S_GAP;
          end else wcnt <= wcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mw_eeprom_host_chk.sv
module mw_eeprom_host_chk #(
  parameter int CSL_CYC = 13
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_cmd,
  input logic       req_ready,
  input logic       done,
  input logic       err,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_di
);
  localparam int LW = $clog2(CSL_CYC + 1);
  logic [LW-1:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowcnt <= LW'(CSL_CYC);
    else if (ee_cs) lowcnt <= '0;
    else if (lowcnt < LW'(CSL_CYC)) lowcnt <= lowcnt + 1'b1;
  end

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cmd <= 3'd4) |=> !req_ready);

  a_r10_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cmd > 3'd4) |=> (done && err && !ee_cs));

  a_r4_di_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  a_r4_sk_framed: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  a_r7_cs_low_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (lowcnt >= LW'(CSL_CYC)));
endmodule

bind mw_eeprom_host mw_eeprom_host_chk #(.CSL_CYC(CSL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_ready(req_ready), .done(done), .err(err),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di)
);

// File: tb/mw_eeprom_host_test.sv
module mw_eeprom_host_test;
  localparam int AW = 6, DWD = 16, DIV = 2, CSL = 13, PMAX = 64, BUSY = 60, NV = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           req_valid = 1'b0;
  logic [2:0]     req_cmd = '0;
  logic [AW-1:0]  req_addr = '0;
  logic [DWD-1:0] req_wdata = '0;
  logic           req_ready, done, err, ee_cs, ee_sk, ee_di, ee_do;
  logic [DWD-1:0] rdata;

  mw_eeprom_host #(.ADDR_W(AW), .DATA_W(DWD), .DIV(DIV), .CSL_CYC(CSL), .POLL_MAX(PMAX)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .done(done), .rdata(rdata), .err(err),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory
  logic [DWD-1:0] mem [64];
  logic [DWD-1:0] ref_mem [64];
  logic m_en = 1'b0, m_do = 1'b0, m_rd = 1'b0, m_stuck = 1'b0;
  int   m_busy = 0;
  bit   started = 0;
  int   n = 0, rbit = 0, last_n = 0, en_frames = 0;
  logic [31:0] sr = '0;
  logic [1:0]  m_op = '0, last_op = '0;
  logic [AW-1:0] m_addr = '0, last_addr = '0;
  logic psk = 1'b0, pcs = 1'b0;

  assign ee_do = ee_cs ? (m_rd ? m_do : (m_busy != 0 ? 1'b0 : 1'b1)) : 1'b0;

  always @(posedge clk) begin
    if (m_busy > 0 && !m_stuck) m_busy <= m_busy - 1;
    if (ee_cs && ee_sk && !psk) begin
      if (!started) begin
        if (ee_di) begin started = 1; n = 0; end
      end else begin
        sr = {sr[30:0], ee_di};
        n++;
        if (m_rd) begin
          rbit--;
          if (rbit >= 0) m_do <= mem[m_addr][rbit];
        end
        if (n == 2 + AW) begin
          m_op = sr[AW+1:AW];
          m_addr = sr[AW-1:0];
          if (m_op == 2'b10) begin m_rd <= 1'b1; m_do <= 1'b0; rbit = DWD; end
        end
      end
    end
    if (!ee_cs && pcs) begin
      if (started) begin
        last_op = m_op; last_addr = m_addr; last_n = n;
        if (n >= 2 + AW) begin
          if (m_op == 2'b01 && n == 2 + AW + DWD && m_en) begin mem[m_addr] = sr[DWD-1:0]; m_busy <= BUSY; end
          if (m_op == 2'b11 && n == 2 + AW && m_en) begin mem[m_addr] = '1; m_busy <= BUSY; end
          if (m_op == 2'b00 && m_addr[AW-1:AW-2] == 2'b11) begin m_en = 1'b1; en_frames++; end
          if (m_op == 2'b00 && m_addr[AW-1:AW-2] == 2'b00) m_en = 1'b0;
        end
      end
      started = 0; n = 0; m_rd <= 1'b0; m_do <= 1'b0;
    end
    psk = ee_sk; pcs = ee_cs;
  end

  // port monitors
  int dcnt = 0, rises = 0, lowlen = 0, minlow = 1000000, skw = 0, badsk = 0, baddi = 0;
  bit seen_fall = 0;
  logic mpcs = 1'b0, mpsk = 1'b0, mpdi = 1'b0;
  always @(posedge clk) begin
    if (done) dcnt++;
    if (ee_cs && !mpcs) begin
      rises++;
      if (seen_fall && lowlen < minlow) minlow = lowlen;
    end
    if (!ee_cs && mpcs) begin seen_fall = 1; lowlen = 1; end
    else if (!ee_cs) lowlen++;
    if (ee_sk) skw++;
    else if (mpsk) begin
      if (rst_n && skw != DIV) badsk++;
      skw = 0;
    end
    if (ee_sk && mpsk && ee_di != mpdi) baddi++;
    mpcs = ee_cs; mpsk = ee_sk; mpdi = ee_di;
  end

  task automatic issue(input logic [2:0] c, input logic [AW-1:0] a, input logic [DWD-1:0] d);
    int d0, w;
    d0 = dcnt;
    @(negedge clk);
    req_cmd = c; req_addr = a; req_wdata = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (c <= 3'd4) chk(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    w = 0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R2 done seen", done, 1);
    @(negedge clk);
    chk(dcnt - d0 == 1, "R2 single done pulse", dcnt - d0, 1);
  endtask

  localparam logic [24:0] VEC [NV] = '{
    {3'd0, 6'd5,  16'h0000}, {3'd1, 6'd5,  16'h1234}, {3'd0, 6'd5,  16'h0000},
    {3'd1, 6'd63, 16'h8001}, {3'd0, 6'd63, 16'h0000}, {3'd2, 6'd5,  16'h0000},
    {3'd0, 6'd5,  16'h0000}, {3'd4, 6'd0,  16'h0000}, {3'd1, 6'd0,  16'h0000},
    {3'd0, 6'd0,  16'h0000}, {3'd0, 6'd42, 16'h0000}, {3'd3, 6'd0,  16'h0000},
    {3'd1, 6'd42, 16'hA55A}, {3'd0, 6'd42, 16'h0000}};

  bit ref_en = 0;
  int ex_en = 0;

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'(i * 16'h0203) ^ 16'h5A3C;
      ref_mem[i] = mem[i];
    end
    repeat (4) @(negedge clk);
    chk(ee_cs == 0 && ee_sk == 0, "R1 link idle in reset", {ee_cs, ee_sk}, 0);
    chk(req_ready == 1 && done == 0 && err == 0, "R1 port idle in reset", {req_ready, done, err}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ee_cs == 0 && req_ready == 1, "R1 idle after reset", {ee_cs, req_ready}, 2'b01);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] c; logic [AW-1:0] a; logic [DWD-1:0] d;
      c = VEC[i][24:22]; a = VEC[i][21:16]; d = VEC[i][15:0];
      if (c == 3'd3 || ((c == 3'd1 || c == 3'd2) && !ref_en)) ex_en++;
      issue(c, a, d);
      chk(err == 0, "R2 no error on legal command", err, 0);
      case (c)
        3'd0: begin
          chk(rdata == ref_mem[a], "R5 read word", rdata, ref_mem[a]);
          chk(last_op == 2'b10 && last_addr == a, "R3 read frame", {last_op, last_addr}, {2'b10, a});
        end
        3'd1: begin
          ref_mem[a] = d; ref_en = 1;
          chk(mem[a] == d, "R9 write took effect", mem[a], d);
          chk(last_op == 2'b01 && last_addr == a, "R3 write frame", {last_op, last_addr}, {2'b01, a});
          chk(last_n == 2 + AW + DWD, "R6 write clock count", last_n, 2 + AW + DWD);
          chk(m_busy == 0, "R6 done after ready", m_busy, 0);
        end
        3'd2: begin
          ref_mem[a] = '1; ref_en = 1;
          chk(mem[a] == 16'hFFFF, "R9 erase took effect", mem[a], 16'hFFFF);
          chk(last_op == 2'b11 && last_n == 2 + AW, "R6 erase frame end", {last_op, 8'(last_n)}, {2'b11, 8'(2 + AW)});
          chk(m_busy == 0, "R6 done after ready", m_busy, 0);
        end
        3'd3: begin
          ref_en = 1;
          chk(last_op == 2'b00 && last_addr[AW-1:AW-2] == 2'b11, "R3 enable frame", {last_op, last_addr[AW-1:AW-2]}, 4'b0011);
        end
        default: begin
          ref_en = 0;
          chk(last_op == 2'b00 && last_addr[AW-1:AW-2] == 2'b00, "R3 disable frame", {last_op, last_addr[AW-1:AW-2]}, 4'b0000);
        end
      endcase
      chk(en_frames == ex_en, "R9 enable frame count", en_frames, ex_en);
    end

    begin
      int r0;
      r0 = rises;
      issue(3'd6, 6'd1, 16'h0);
      chk(err == 1, "R10 unknown code error", err, 1);
      chk(rises == r0, "R10 no chip select", rises - r0, 0);
    end

    m_stuck = 1'b1;
    issue(3'd1, 6'd7, 16'hBEEF);
    chk(err == 1, "R8 timeout error", err, 1);
    chk(ee_cs == 0, "R8 chip select dropped", ee_cs, 0);
    m_stuck = 1'b0;
    ref_mem[7] = 16'hBEEF;
    issue(3'd0, 6'd7, 16'h0);
    chk(err == 0, "R8 error cleared", err, 0);
    chk(rdata == 16'hBEEF, "R5 read after timeout", rdata, 16'hBEEF);

    @(negedge clk);
    req_cmd = 3'd1; req_addr = 6'd9; req_wdata = 16'h7777; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ee_cs == 0 && ee_sk == 0, "R1 reset mid frame link", {ee_cs, ee_sk}, 0);
    chk(req_ready == 1 && done == 0, "R1 reset mid frame port", {req_ready, done}, 2'b10);
    rst_n = 1'b1;
    ref_en = 0;
    repeat (20) @(negedge clk);
    ex_en = en_frames + 1;
    issue(3'd1, 6'd9, 16'h0F0F);
    chk(en_frames == ex_en, "R9 enable resent after reset", en_frames, ex_en);
    issue(3'd0, 6'd9, 16'h0);
    chk(rdata == 16'h0F0F, "R5 read after reset", rdata, 16'h0F0F);

    chk(badsk == 0, "R4 clock high width", badsk, 0);
    chk(baddi == 0, "R4 data steady while clock high", baddi, 0);
    chk(minlow >= CSL, "R7 chip select low time", minlow, CSL);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule